// File: doc/BRIEF.md
# IDE PIO Cycle Timing Engine

This block generates the host-side strobes for ATA programmed-I/O transfers on two channels with two drives each. A small byte-wide register file holds, per drive, a two-bit address-setup code and a byte with two four-bit strobe counts: one for the active phase and one for the recovery phase. When a transfer is requested for a drive index, the engine latches that drive's decoded counts, holds the address for the setup phase, drives the read or write strobe low for the active phase, then idles the bus for the recovery phase before pulsing a one-clock ready.

The second channel has a single setup register and a single strobe-count register, both used by drives 2 and 3. The per-drive prefetch-disable bits are stored in the same register file and exported as a four-bit vector. A command-timing register forces the slowest bus timing for command-block accesses while it reads zero. A chip revision input lengthens every recovery phase by one clock when it is above 1.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset the register file reads index 0..7 as 00,00,00,00,0C,00,C0,00, pf_dis is 4'hF, both strobes are high, busy and ready are low; so every drive runs setup 4, active 16, recovery 16 clocks.
- R2: The setup code is bits 7:6 of a drive's setup register (index 0 for drive 0, 2 for drive 1, 4 for drives 2 and 3); code 00 gives 4 clocks, 01 gives 2, 10 gives 3 and 11 gives 5.
- R3: In a strobe-count register (index 1, 3 or 5) bits 7:4 give the active clocks and bits 3:0 the recovery clocks, a nibble of 0 meaning 16.
- R4: An active nibble of 1 produces a 2-clock active phase.
- R5: A recovery nibble of 1 produces 2 recovery clocks when the effective active count is above 3, and 1 clock otherwise.
- R6: When chip_rev is greater than 1, every recovery phase lasts one clock more than R3 and R5 give.
- R7: Drives 0 and 1 use their own register pair; drives 2 and 3 both use indices 4 and 5, and a change to one drive's pair does not alter another pair's timing.
- R8: pf_dis bit 0 is bit 6 of index 6, bit 1 is bit 7 of index 6, bit 2 is bit 2 of index 4, bit 3 is bit 3 of index 4; all bits of the setup registers are stored, and bits 5:0 have no effect on timing.
- R9: A command-block access while index 7 holds 0 runs setup 5, active 16, recovery 16 (plus R6) whatever the drive's registers say; with index 7 nonzero it uses the drive's own timing.
- R10: A request is taken only when idle; the phases run setup, active, recovery, then ready is high for exactly one clock, the address output stays stable while busy, and a request made while busy is dropped.
- R11: A read drives only ide_rd_n low and captures ide_dd_i on the last active clock into rdata; a write drives only ide_wr_n low while ide_dd_o carries the request data and ide_dd_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register file write enable |
| cfg_addr | input | 3 | Register index for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data at cfg_addr |
| chip_rev | input | 2 | Chip revision; above 1 lengthens recovery |
| req | input | 1 | Transfer request |
| req_drive | input | 2 | Drive index 0..3 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cmdblk | input | 1 | Access targets the command register block |
| req_addr | input | 3 | Register address on the drive bus |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | One-clock completion pulse |
| busy | output | 1 | Transfer in progress |
| rdata | output | 16 | Captured read data |
| ide_addr | output | 3 | Drive bus address, held for the transfer |
| ide_cmdblk | output | 1 | Command-block select, held for the transfer |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_dd_o | output | 16 | Drive bus write data |
| ide_dd_oe | output | 1 | Drive bus output enable |
| ide_dd_i | input | 16 | Drive bus read data |
| pf_dis | output | 4 | Per-drive prefetch disable |

## Verification
Each transfer's setup, active and recovery lengths are measured at the strobes and compared with the value the requirements predict, so a swapped setup code, a missing zero-to-16 mapping or an off-by-one phase shows up as a wrong count. Nibble patterns of 1 paired with active counts of 2, 3, 4 and 5 separate the two minimum-count rules, and the revision input is swept to isolate the extra recovery clock. Drives 2 and 3 are run after their shared registers change while drive 0's timing is rechecked, telling shared from private sets, and command-block accesses with the override register at zero and nonzero separate the forced slow path from the per-drive path.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int MAX_PHASE_CLKS = 17;
  localparam int CNT_W          = $clog2(MAX_PHASE_CLKS + 1);
  localparam int NUM_REGS       = 8;
  localparam int RI_W           = $clog2(NUM_REGS);
  localparam int NUM_DRIVES     = 4;
  localparam int DRV_W          = $clog2(NUM_DRIVES);

  localparam logic [RI_W-1:0] RI_SET0  = 3'd0;
  localparam logic [RI_W-1:0] RI_TIM0  = 3'd1;
  localparam logic [RI_W-1:0] RI_SET1  = 3'd2;
  localparam logic [RI_W-1:0] RI_TIM1  = 3'd3;
  localparam logic [RI_W-1:0] RI_SET23 = 3'd4;
  localparam logic [RI_W-1:0] RI_TIM23 = 3'd5;
  localparam logic [RI_W-1:0] RI_CTRL  = 3'd6;
  localparam logic [RI_W-1:0] RI_CMDT  = 3'd7;

  localparam logic [CNT_W-1:0] SLOW_SETUP = CNT_W'(5);
  localparam logic [CNT_W-1:0] SLOW_ACT   = CNT_W'(16);
  localparam logic [CNT_W-1:0] SLOW_REC   = CNT_W'(16);

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV
  } phase_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
  } phase_counts_t;
endpackage

// File: rtl/ide_pio_regs.sv
module ide_pio_regs
  import ide_pio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RI_W-1:0] addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [DRV_W-1:0] drive,
  output logic [7:0]      set_byte,
  output logic [7:0]      tim_byte,
  output logic [7:0]      cmd_byte,
  output logic [NUM_DRIVES-1:0] pf_dis
);
  function automatic logic [7:0] reset_value(int idx);
    case (idx)
      int'(RI_SET23): return 8'h0C;
      int'(RI_CTRL):  return 8'hC0;
      default:        return 8'h00;
    endcase
  endfunction

  logic [7:0] reg_q [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic hit;
    assign hit = we && (addr == RI_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[gi] <= reset_value(gi);
      end else if (hit) begin
        reg_q[gi] <= wdata;
      end
    end
  end

  assign rdata    = reg_q[addr];
  assign cmd_byte = reg_q[RI_CMDT];

  always_comb begin
    case (drive)
      2'd0:    begin set_byte = reg_q[RI_SET0];  tim_byte = reg_q[RI_TIM0];  end
      2'd1:    begin set_byte = reg_q[RI_SET1];  tim_byte = reg_q[RI_TIM1];  end
      default: begin set_byte = reg_q[RI_SET23]; tim_byte = reg_q[RI_TIM23]; end
    endcase
  end

  assign pf_dis = {reg_q[RI_SET23][3], reg_q[RI_SET23][2],
                   reg_q[RI_CTRL][7],  reg_q[RI_CTRL][6]};

  // R8: prefetch vector tracks the register bits one clock after a write
  assert_pf_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RI_CTRL) |=> (pf_dis[1:0] == $past({wdata[7], wdata[6]})));
endmodule

// File: rtl/ide_pio_decode.sv
module ide_pio_decode
  import ide_pio_pkg::*;
(
  input  logic [7:0]    set_byte,
  input  logic [7:0]    tim_byte,
  input  logic [7:0]    cmd_byte,
  input  logic          cmdblk,
  input  logic [1:0]    rev,
  output phase_counts_t counts
);
  logic [CNT_W-1:0] setup_c, act_raw, act_c, rec_raw, rec_c;
  logic             rev_long;

  always_comb begin
    case (set_byte[7:6])
      2'b00:   setup_c = CNT_W'(4);
      2'b10:   setup_c = CNT_W'(3);
      2'b01:   setup_c = CNT_W'(2);
      default: setup_c = CNT_W'(5);
    endcase
  end

  assign act_raw  = (tim_byte[7:4] == 4'd0) ? CNT_W'(16) : CNT_W'(tim_byte[7:4]);
  assign act_c    = (act_raw == CNT_W'(1)) ? CNT_W'(2) : act_raw;
  assign rec_raw  = (tim_byte[3:0] == 4'd0) ? CNT_W'(16) : CNT_W'(tim_byte[3:0]);
  assign rec_c    = ((rec_raw == CNT_W'(1)) && (act_c > CNT_W'(3))) ? CNT_W'(2) : rec_raw;
  assign rev_long = (rev > 2'd1);

  always_comb begin
    if (cmdblk && (cmd_byte == 8'd0)) begin
      counts.setup  = SLOW_SETUP;
      counts.active = SLOW_ACT;
      counts.recov  = SLOW_REC + CNT_W'(rev_long);
    end else begin
      counts.setup  = setup_c;
      counts.active = act_c;
      counts.recov  = rec_c + CNT_W'(rev_long);
    end
  end
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_cmdblk,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_counts_t     counts,
  input  logic [DATA_W-1:0] dd_i,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cmdblk_o,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              ready
);
  phase_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, rec_q;
  logic             wr_q, accept, capture;
  logic             rd_n_d, wr_n_d, oe_d, ready_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    accept = 1'b0;
    case (st_q)
      PH_IDLE: begin
        if (req) begin
          accept = 1'b1;
          st_d   = PH_SETUP;
          cnt_d  = counts.setup - CNT_W'(1);
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = PH_ACTIVE;
          cnt_d = act_q - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) begin
          st_d  = PH_RECOV;
          cnt_d = rec_q - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        if (cnt_q == '0) begin
          st_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    endcase
  end

  assign rd_n_d  = !((st_d == PH_ACTIVE) && !wr_q);
  assign wr_n_d  = !((st_d == PH_ACTIVE) && wr_q);
  assign oe_d    = (st_d != PH_IDLE) && (accept ? req_write : wr_q);
  assign ready_d = (st_q == PH_RECOV) && (cnt_q == '0);
  assign capture = (st_q == PH_ACTIVE) && (cnt_q == '0) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PH_IDLE;
      cnt_q    <= '0;
      act_q    <= '0;
      rec_q    <= '0;
      wr_q     <= 1'b0;
      addr_o   <= '0;
      cmdblk_o <= 1'b0;
      dd_o     <= '0;
      dd_oe    <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      ready    <= 1'b0;
      rdata    <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rd_n  <= rd_n_d;
      wr_n  <= wr_n_d;
      dd_oe <= oe_d;
      ready <= ready_d;
      if (accept) begin
        act_q    <= counts.active;
        rec_q    <= counts.recov;
        wr_q     <= req_write;
        addr_o   <= req_addr;
        cmdblk_o <= req_cmdblk;
        dd_o     <= req_wdata;
      end
      if (capture) begin
        rdata <= dd_i;
      end
    end
  end

  assign busy = (st_q != PH_IDLE);

  // R11: read and write strobes never low together, and only during a transfer
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_strobe_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> busy);
  // R4: an active phase is never shorter than two clocks
  assert_act_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n && wr_n) |=> !(rd_n && wr_n));
  // R10: ready is a single-clock pulse seen in idle
  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy);
  // R10: the bus address holds for the whole transfer
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_o));
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [1:0]        chip_rev,
  input  logic              req,
  input  logic [1:0]        req_drive,
  input  logic              req_write,
  input  logic              req_cmdblk,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ide_addr,
  output logic              ide_cmdblk,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic [DATA_W-1:0] ide_dd_o,
  output logic              ide_dd_oe,
  input  logic [DATA_W-1:0] ide_dd_i,
  output logic [3:0]        pf_dis
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [7:0]    set_byte, tim_byte, cmd_byte;
  phase_counts_t counts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ide_pio_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .drive    (req_drive),
    .set_byte (set_byte),
    .tim_byte (tim_byte),
    .cmd_byte (cmd_byte),
    .pf_dis   (pf_dis)
  );

  ide_pio_decode u_decode (
    .set_byte (set_byte),
    .tim_byte (tim_byte),
    .cmd_byte (cmd_byte),
    .cmdblk   (req_cmdblk),
    .rev      (chip_rev),
    .counts   (counts)
  );

  ide_pio_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req        (req),
    .req_write  (req_write),
    .req_cmdblk (req_cmdblk),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .counts     (counts),
    .dd_i       (ide_dd_i),
    .rd_n       (ide_rd_n),
    .wr_n       (ide_wr_n),
    .addr_o     (ide_addr),
    .cmdblk_o   (ide_cmdblk),
    .dd_o       (ide_dd_o),
    .dd_oe      (ide_dd_oe),
    .rdata      (rdata),
    .busy       (busy),
    .ready      (ready)
  );
endmodule

// File: tb/sim_ide_pio_timer.sv
module sim_ide_pio_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [1:0]  chip_rev = 2'd1;
  logic        req = 1'b0;
  logic [1:0]  req_drive = '0;
  logic        req_write = 1'b0;
  logic        req_cmdblk = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        ready, busy;
  logic [15:0] rdata;
  logic [2:0]  ide_addr;
  logic        ide_cmdblk, ide_rd_n, ide_wr_n, ide_dd_oe;
  logic [15:0] ide_dd_o;
  logic [15:0] ide_dd_i = '0;
  logic [3:0]  pf_dis;

  always #5 clk = ~clk;

  ide_pio_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chip_rev(chip_rev),
    .req(req), .req_drive(req_drive), .req_write(req_write),
    .req_cmdblk(req_cmdblk), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .busy(busy), .rdata(rdata), .ide_addr(ide_addr),
    .ide_cmdblk(ide_cmdblk), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
    .ide_dd_o(ide_dd_o), .ide_dd_oe(ide_dd_oe), .ide_dd_i(ide_dd_i),
    .pf_dis(pf_dis)
  );

  typedef struct {
    int          s;
    int          a;
    int          r;
    bit          wr;
    logic [15:0] data;
    logic [2:0]  addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   done_cnt = 0;
  int   m_s = 0, m_a_rd = 0, m_a_wr = 0, m_r = 0;
  bit   m_bus_bad = 0;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: measures phases at the strobes and scores each completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "completion without accepted request", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(m_s == e.s, e.tag, "setup clocks", m_s, e.s);
          check((e.wr ? m_a_wr : m_a_rd) == e.a && (e.wr ? m_a_rd : m_a_wr) == 0,
                e.tag, "active clocks on expected strobe only",
                e.wr ? m_a_wr : m_a_rd, e.a);
          check(m_r == e.r, e.tag, "recovery clocks", m_r, e.r);
          check(!m_bus_bad, e.tag, "address/data held on bus", 1, 0);
          if (!e.wr) check(rdata === e.data, e.tag, "read data", rdata, e.data);
        end
        done_cnt++;
        m_s = 0; m_a_rd = 0; m_a_wr = 0; m_r = 0; m_bus_bad = 0;
      end else if (busy) begin
        if (q.size() > 0 && ide_addr !== q[0].addr) m_bus_bad = 1;
        if (!ide_rd_n) m_a_rd++;
        if (!ide_wr_n) begin
          m_a_wr++;
          if (q.size() > 0 && (ide_dd_o !== q[0].data || !ide_dd_oe)) m_bus_bad = 1;
        end
        if (ide_rd_n && ide_wr_n) begin
          if (m_a_rd + m_a_wr == 0) m_s++;
          else m_r++;
        end
      end
    end
  end

  task automatic cfg_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata === exp, tag, $sformatf("register %0d", a), cfg_rdata, exp);
  endtask

  task automatic pulse_req(int drv, bit wr, bit cmd, logic [15:0] data, logic [2:0] ad);
    @(negedge clk);
    req = 1'b1; req_drive = 2'(drv); req_write = wr; req_cmdblk = cmd;
    req_addr = ad; req_wdata = data;
    if (!wr) ide_dd_i = data;
    @(negedge clk);
    req = 1'b0;
  endtask

  // Driver: pushes the expectation, issues the request, waits for scoring
  task automatic xfer(int drv, bit wr, bit cmd, logic [15:0] data, logic [2:0] ad,
                      int s, int a, int r, string tag);
    exp_t e;
    int   n;
    e.s = s; e.a = a; e.r = r; e.wr = wr; e.data = data; e.addr = ad; e.tag = tag;
    q.push_back(e);
    n = done_cnt;
    pulse_req(drv, wr, cmd, data, ad);
    wait (done_cnt == n + 1);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    cfg_check(3'd0, 8'h00, "R1"); cfg_check(3'd1, 8'h00, "R1");
    cfg_check(3'd2, 8'h00, "R1"); cfg_check(3'd3, 8'h00, "R1");
    cfg_check(3'd4, 8'h0C, "R1"); cfg_check(3'd5, 8'h00, "R1");
    cfg_check(3'd6, 8'hC0, "R1"); cfg_check(3'd7, 8'h00, "R1");
    check(pf_dis === 4'hF, "R1", "pf_dis", pf_dis, 4'hF);
    check(ide_rd_n && ide_wr_n && !busy && !ready, "R1", "idle outputs",
          {ide_rd_n, ide_wr_n, busy, ready}, 4'b1100);
    xfer(0, 0, 0, 16'hA5A5, 3'd0, 4, 16, 16, "R1_R3 default drive0");
    xfer(3, 0, 0, 16'h5A5A, 3'd1, 4, 16, 16, "R1_R3 default drive3");

    // R2: setup code decoding, low bits stored but ignored (R8)
    cfg_write(3'd1, 8'h32);
    cfg_write(3'd0, 8'h15); xfer(0, 0, 0, 16'h0001, 3'd2, 4, 3, 2, "R2 code00");
    cfg_write(3'd0, 8'h55); xfer(0, 0, 0, 16'h0002, 3'd3, 2, 3, 2, "R2 code01");
    cfg_write(3'd0, 8'h95); xfer(0, 0, 0, 16'h0003, 3'd4, 3, 3, 2, "R2 code10");
    cfg_write(3'd0, 8'hD5); xfer(0, 0, 0, 16'h0004, 3'd5, 5, 3, 2, "R2 code11");
    cfg_check(3'd0, 8'hD5, "R8");

    // R4 and R5: minimum-count rules
    cfg_write(3'd1, 8'h13); xfer(0, 0, 0, 16'h1111, 3'd6, 5, 2, 3, "R4 active1");
    cfg_write(3'd1, 8'h51); xfer(0, 0, 0, 16'h2222, 3'd7, 5, 5, 2, "R5 act5 rec1");
    cfg_write(3'd1, 8'h41); xfer(0, 0, 0, 16'h3333, 3'd0, 5, 4, 2, "R5 act4 rec1");
    cfg_write(3'd1, 8'h31); xfer(0, 0, 0, 16'h4444, 3'd1, 5, 3, 1, "R5 act3 rec1");
    cfg_write(3'd1, 8'h11); xfer(0, 0, 0, 16'h5555, 3'd2, 5, 2, 1, "R5_R4 act1 rec1");

    // R6: revision lengthens recovery
    chip_rev = 2'd2;
    cfg_write(3'd1, 8'h51); xfer(0, 0, 0, 16'h6666, 3'd3, 5, 5, 3, "R6 rev2 rec1");
    cfg_write(3'd1, 8'h00); xfer(0, 0, 0, 16'h7777, 3'd4, 5, 16, 17, "R6 rev2 rec16");
    chip_rev = 2'd3;
    cfg_write(3'd1, 8'h24); xfer(0, 0, 0, 16'h8888, 3'd5, 5, 2, 5, "R6 rev3");
    chip_rev = 2'd0;
    xfer(0, 0, 0, 16'h9999, 3'd6, 5, 2, 4, "R6 rev0");
    chip_rev = 2'd1;

    // R7: private pairs for drives 0/1, shared pair for drives 2/3
    cfg_write(3'd2, 8'h80); cfg_write(3'd3, 8'h78);
    xfer(1, 0, 0, 16'hAAAA, 3'd7, 3, 7, 8, "R7 drive1 own");
    xfer(0, 0, 0, 16'hBBBB, 3'd0, 5, 2, 4, "R7 drive0 untouched");
    cfg_write(3'd4, 8'h4C); cfg_write(3'd5, 8'h96);
    xfer(2, 0, 0, 16'hCCCC, 3'd1, 2, 9, 6, "R7 drive2 shared");
    xfer(3, 0, 0, 16'hDDDD, 3'd2, 2, 9, 6, "R7 drive3 shared");
    xfer(1, 0, 0, 16'hEEEE, 3'd3, 3, 7, 8, "R7 drive1 untouched");

    // R8: prefetch bit mapping; setup register low bits leave timing alone
    cfg_write(3'd6, 8'h40);
    check(pf_dis === 4'b1101, "R8", "pf_dis ctrl", pf_dis, 4'b1101);
    cfg_write(3'd4, 8'h44);
    check(pf_dis === 4'b0101, "R8", "pf_dis shared", pf_dis, 4'b0101);
    cfg_write(3'd6, 8'h80);
    check(pf_dis === 4'b0110, "R8", "pf_dis ctrl swap", pf_dis, 4'b0110);
    xfer(3, 0, 0, 16'h0F0F, 3'd4, 2, 9, 6, "R8 low bits ignored");

    // R9: command-block override
    xfer(1, 0, 1, 16'h1357, 3'd5, 5, 16, 16, "R9 override");
    chip_rev = 2'd2;
    xfer(1, 0, 1, 16'h2468, 3'd6, 5, 16, 17, "R9_R6 override rev2");
    chip_rev = 2'd1;
    cfg_write(3'd7, 8'h01);
    xfer(1, 0, 1, 16'h369C, 3'd7, 3, 7, 8, "R9 override off");
    cfg_write(3'd7, 8'h00);

    // R11: writes use the write strobe and drive data
    xfer(2, 1, 0, 16'h1234, 3'd0, 2, 9, 6, "R11 write drive2");
    xfer(0, 1, 0, 16'hFEDC, 3'd1, 5, 2, 4, "R11 write drive0");
    xfer(1, 0, 0, 16'hC3C3, 3'd2, 3, 7, 8, "R11 read after write");

    // R10: request during busy is dropped
    begin
      exp_t e;
      int   n;
      e.s = 3; e.a = 7; e.r = 8; e.wr = 0; e.data = 16'h7E7E; e.addr = 3'd3;
      e.tag = "R10 busy request";
      q.push_back(e);
      n = done_cnt;
      pulse_req(1, 0, 0, 16'h7E7E, 3'd3);
      repeat (5) @(negedge clk);
      req = 1'b1; req_drive = 2'd0; req_write = 1'b1; req_addr = 3'd6;
      @(negedge clk);
      req = 1'b0;
      wait (done_cnt == n + 1);
      repeat (40) @(negedge clk);
      check(!busy && q.size() == 0 && done_cnt == n + 1, "R10",
            "no transfer from busy request", done_cnt - n, 1);
    end

    summary();
  end
endmodule